// File: doc/BRIEF.md
# Burst Address Sequencer with Order Select

This block generates the word address for a four-beat burst access to a synchronous memory array. A burst begins when one of two start strobes is accepted. The processor-side start takes priority. The controller-side start counts only while the processor-side strobe is inactive. On an accepted start, the block captures the external address. On later clock edges it steps the low address bits whenever the advance strobe is active. When advance is inactive, it holds the address.

A static order input selects the stepping order. In linear order the low bits count upward modulo the burst length. In interleaved order they are the captured low bits XOR a beat counter. The upper address bits never change within a burst.

Three chip selects gate every start. A start that arrives while the device is not selected produces a deselect cycle. Each cycle also reports its type (begin, continue, suspend or deselect) and whether the current burst was opened by the processor-side strobe.

Top module: `burst_seq`

## Requirements
- R1: While reset is active and in the first cycle after it, cyc_type is 0 (deselect), mem_addr is 0 and from_proc is 0.
- R2: If start_proc_n is low, sel1_n is low and the device is selected, the block begins a burst. The next cycle shows cyc_type 1 (begin), mem_addr equal to addr_in and from_proc 1. adv_n has no effect on that edge.
- R3: start_ctrl_n low begins a burst only while start_proc_n is high. Such a burst shows from_proc 0. When both strobes are low and sel1_n is low, the processor-side start wins.
- R4: When sel1_n is high, start_proc_n is ignored. With start_ctrl_n high, the edge is treated as a continue or suspend edge.
- R5: The device is selected only when sel1_n=0, sel2=1 and sel3_n=0. An accepted start strobe while unselected gives cyc_type 0, and mem_addr and from_proc keep their values. Until the next begin, later edges without an accepted start also give cyc_type 0.
- R6: With order_ilv=0, each continue edge (no accepted start, adv_n low, burst active) gives cyc_type 2 and increments the two low address bits modulo 4.
- R7: With order_ilv=1, the low bits on beat k equal the captured low bits XOR k. For example, a start at 01 gives 01, 00, 11, 10.
- R8: After four beats the low bits return to the captured start value.
- R9: A burst-active edge with no accepted start and adv_n high gives cyc_type 3 (suspend), and mem_addr is unchanged.
- R10: Within a burst, only the two low bits of mem_addr change.
- R11: An accepted start in the middle of a burst replaces the base address and restarts the beat count at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_in | input | ADDR_W | External word address |
| start_proc_n | input | 1 | Processor-side start strobe, active low |
| start_ctrl_n | input | 1 | Controller-side start strobe, active low |
| adv_n | input | 1 | Burst advance strobe, active low |
| sel1_n | input | 1 | Chip select 1, active low; also gates start_proc_n |
| sel2 | input | 1 | Chip select 2, active high |
| sel3_n | input | 1 | Chip select 3, active low |
| order_ilv | input | 1 | Burst order: 1 interleaved, 0 linear (static) |
| mem_addr | output | ADDR_W | Current array address |
| cyc_type | output | 2 | 0 deselect, 1 begin, 2 continue, 3 suspend |
| from_proc | output | 1 | Current burst opened by processor-side strobe |

## Verification
The hardest case to reach from the ports is a strobe that is ignored but not idle. In this case start_proc_n is low while sel1_n is high, in the middle of an active burst. To the sequencer this must look exactly like a plain continue edge. The stimulus table builds an interleaved burst, wraps it once, and then drives this masked strobe with adv_n low. The bench checks that the address takes its next interleaved step and that from_proc stays low. The same table then forces both priority orders and mid-burst restarts from each strobe.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
   typedef enum logic [1:0] {
      CYC_DESEL = 2'd0,
      CYC_BEGIN = 2'd1,
      CYC_CONT  = 2'd2,
      CYC_SUSP  = 2'd3
   } cyc_e;
endpackage

// File: rtl/burst_seq_accept.sv
module burst_seq_accept (
   input  logic start_proc_n,
   input  logic start_ctrl_n,
   input  logic sel1_n,
   input  logic sel2,
   input  logic sel3_n,
   output logic take_proc,
   output logic take_ctrl,
   output logic selected
);
   always_comb begin
      selected  = !sel1_n && sel2 && !sel3_n;
      // sel1 high masks the processor strobe entirely
      take_proc = !start_proc_n && !sel1_n;
      // controller strobe counts only while processor strobe is idle
      take_ctrl = !start_ctrl_n && start_proc_n;
   end
endmodule

// File: rtl/burst_seq_order.sv
module burst_seq_order #(
   parameter int CNT_W = 2
) (
   input  logic [CNT_W-1:0] base_lo,
   input  logic [CNT_W-1:0] beat,
   input  logic             order_ilv,
   output logic [CNT_W-1:0] cur_lo
);
   logic [CNT_W-1:0] ilv_lo;
   logic [CNT_W-1:0] lin_lo;

   for (genvar b = 0; b < CNT_W; b++) begin : g_ilv_bit
      assign ilv_lo[b] = base_lo[b] ^ beat[b];
   end

   assign lin_lo = base_lo + beat;
   assign cur_lo = order_ilv ? ilv_lo : lin_lo;
endmodule

// File: rtl/burst_seq.sv
module burst_seq
   import burst_seq_pkg::*;
#(
   parameter int ADDR_W = 18,
   parameter int BEATS  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              start_proc_n,
   input  logic              start_ctrl_n,
   input  logic              adv_n,
   input  logic              sel1_n,
   input  logic              sel2,
   input  logic              sel3_n,
   input  logic              order_ilv,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [1:0]        cyc_type,
   output logic              from_proc
);
   localparam int CNT_W = $clog2(BEATS);

   if (BEATS < 2 || (1 << CNT_W) != BEATS) begin : g_bad_beats
      $error("BEATS must be a power of two of at least 2");
   end
   if (ADDR_W <= CNT_W) begin : g_bad_width
      $error("ADDR_W must exceed the beat counter width");
   end

   logic              take_proc, take_ctrl, selected, take_any;
   logic [ADDR_W-1:0] base_q;
   logic [CNT_W-1:0]  beat_q;
   logic [CNT_W-1:0]  cur_lo;
   logic              active_q;
   cyc_e              cyc_q;

   burst_seq_accept u_accept (
      .start_proc_n (start_proc_n),
      .start_ctrl_n (start_ctrl_n),
      .sel1_n       (sel1_n),
      .sel2         (sel2),
      .sel3_n       (sel3_n),
      .take_proc    (take_proc),
      .take_ctrl    (take_ctrl),
      .selected     (selected)
   );

   assign take_any = take_proc || take_ctrl;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q    <= '0;
         beat_q    <= '0;
         active_q  <= 1'b0;
         cyc_q     <= CYC_DESEL;
         from_proc <= 1'b0;
      end else if (take_any) begin
         if (selected) begin
            base_q    <= addr_in;
            beat_q    <= '0;
            active_q  <= 1'b1;
            cyc_q     <= CYC_BEGIN;
            from_proc <= take_proc;
         end else begin
            active_q <= 1'b0;
            cyc_q    <= CYC_DESEL;
         end
      end else if (active_q) begin
         if (!adv_n) begin
            beat_q <= beat_q + 1'b1;
            cyc_q  <= CYC_CONT;
         end else begin
            cyc_q  <= CYC_SUSP;
         end
      end else begin
         cyc_q <= CYC_DESEL;
      end
   end

   burst_seq_order #(.CNT_W(CNT_W)) u_order (
      .base_lo   (base_q[CNT_W-1:0]),
      .beat      (beat_q),
      .order_ilv (order_ilv),
      .cur_lo    (cur_lo)
   );

   assign mem_addr = {base_q[ADDR_W-1:CNT_W], cur_lo};
   assign cyc_type = cyc_q;

   // R2
   begin_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_type == CYC_BEGIN) |-> (mem_addr == $past(addr_in)));

   // R5
   unselected_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take_any && !selected) |=> (cyc_type == CYC_DESEL && $stable(mem_addr)));

   // R9
   suspend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_type == CYC_SUSP) |-> $stable(mem_addr));

   // R6
   linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_type == CYC_CONT && !order_ilv && $stable(order_ilv)) |->
      (mem_addr[CNT_W-1:0] == CNT_W'($past(mem_addr[CNT_W-1:0]) + 1'b1)));

   // R10
   upper_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_type == CYC_CONT || cyc_type == CYC_SUSP) |->
      $stable(mem_addr[ADDR_W-1:CNT_W]));
endmodule

// File: tb/burst_seq_tb.sv
module burst_seq_tb_top;
   localparam int AW = 18;

   typedef struct packed {
      logic          pn, cn, an, s1n, s2, s3n, ilv;
      logic [AW-1:0] addr;
      logic [1:0]    ecyc;
      logic [AW-1:0] eaddr;
      logic          efp;
      logic [7:0]    req;
   } vec_t;

   localparam int NV = 21;
   localparam vec_t TBL [NV] = '{
      '{0,1,0, 0,1,0, 0, 18'h12346, 2'd1, 18'h12346, 1, 8'd2 },  // R2 adv ignored at start
      '{1,1,0, 0,1,0, 0, 18'h00000, 2'd2, 18'h12347, 1, 8'd6 },  // R6
      '{1,1,0, 0,1,0, 0, 18'h00000, 2'd2, 18'h12344, 1, 8'd6 },  // R6 wrap 11->00
      '{1,1,1, 0,1,0, 0, 18'h00000, 2'd3, 18'h12344, 1, 8'd9 },  // R9
      '{1,1,0, 0,1,0, 0, 18'h00000, 2'd2, 18'h12345, 1, 8'd10},  // R10
      '{1,1,0, 0,1,0, 0, 18'h00000, 2'd2, 18'h12346, 1, 8'd8 },  // R8
      '{1,0,1, 0,1,0, 1, 18'h0ABC1, 2'd1, 18'h0ABC1, 0, 8'd3 },  // R3
      '{1,1,0, 0,1,0, 1, 18'h00000, 2'd2, 18'h0ABC0, 0, 8'd7 },  // R7
      '{1,1,0, 0,1,0, 1, 18'h00000, 2'd2, 18'h0ABC3, 0, 8'd7 },  // R7
      '{1,1,0, 0,1,0, 1, 18'h00000, 2'd2, 18'h0ABC2, 0, 8'd7 },  // R7
      '{1,1,0, 0,1,0, 1, 18'h00000, 2'd2, 18'h0ABC1, 0, 8'd8 },  // R8
      '{0,1,0, 1,1,0, 1, 18'h3FFFF, 2'd2, 18'h0ABC0, 0, 8'd4 },  // R4 masked strobe
      '{1,0,0, 0,0,0, 1, 18'h3FFFF, 2'd0, 18'h0ABC0, 0, 8'd5 },  // R5
      '{1,1,0, 0,1,0, 1, 18'h00000, 2'd0, 18'h0ABC0, 0, 8'd5 },  // R5 stays deselected
      '{0,1,1, 0,1,0, 0, 18'h3FFFF, 2'd1, 18'h3FFFF, 1, 8'd2 },  // R2
      '{1,1,0, 0,1,0, 0, 18'h00000, 2'd2, 18'h3FFFC, 1, 8'd10},  // R10
      '{0,0,0, 0,1,0, 0, 18'h00002, 2'd1, 18'h00002, 1, 8'd3 },  // R3 priority
      '{1,1,0, 0,1,0, 0, 18'h00000, 2'd2, 18'h00003, 1, 8'd11},  // R11
      '{1,0,0, 0,1,0, 0, 18'h15555, 2'd1, 18'h15555, 0, 8'd11},  // R11
      '{1,1,0, 0,1,0, 0, 18'h00000, 2'd2, 18'h15556, 0, 8'd11},  // R11
      '{0,1,0, 0,1,1, 0, 18'h2AAAA, 2'd0, 18'h15556, 0, 8'd5 }   // R5
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr_in = '0;
   logic          start_proc_n = 1'b1, start_ctrl_n = 1'b1, adv_n = 1'b1;
   logic          sel1_n = 1'b1, sel2 = 1'b0, sel3_n = 1'b1, order_ilv = 1'b0;
   logic [AW-1:0] mem_addr;
   logic [1:0]    cyc_type;
   logic          from_proc;
   int            n_chk = 0, n_err = 0;

   always #4 clk = ~clk;

   burst_seq #(.ADDR_W(AW)) dut_i (
      .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
      .start_proc_n(start_proc_n), .start_ctrl_n(start_ctrl_n), .adv_n(adv_n),
      .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n), .order_ilv(order_ilv),
      .mem_addr(mem_addr), .cyc_type(cyc_type), .from_proc(from_proc)
   );

   task automatic check(input int req, input logic [1:0] ec,
                        input logic [AW-1:0] ea, input logic efp);
      n_chk++;
      if (cyc_type !== ec || mem_addr !== ea || from_proc !== efp) begin
         n_err++;
         $display("FAIL R%0d: cyc=%0d addr=%h fp=%0b expected cyc=%0d addr=%h fp=%0b",
                  req, cyc_type, mem_addr, from_proc, ec, ea, efp);
      end
   endtask

   initial begin
      #1000000;
      n_err++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(1, 2'd0, '0, 1'b0);  // R1 during reset
      rst_n = 1'b1;
      @(negedge clk);
      check(1, 2'd0, '0, 1'b0);  // R1 first cycle after reset
      for (int i = 0; i < NV; i++) begin
         {start_proc_n, start_ctrl_n, adv_n} = {TBL[i].pn, TBL[i].cn, TBL[i].an};
         {sel1_n, sel2, sel3_n} = {TBL[i].s1n, TBL[i].s2, TBL[i].s3n};
         order_ilv = TBL[i].ilv;
         addr_in   = TBL[i].addr;
         @(negedge clk);
         check(int'(TBL[i].req), TBL[i].ecyc, TBL[i].eaddr, TBL[i].efp);
      end
      // R1: reset mid-burst returns to deselect, address zero
      {start_proc_n, start_ctrl_n, adv_n} = 3'b010;
      {sel1_n, sel2, sel3_n} = 3'b010;
      addr_in = 18'h3C3C3;
      @(negedge clk);
      check(2, 2'd1, 18'h3C3C3, 1'b1);  // R2
      rst_n = 1'b0;
      {start_proc_n, start_ctrl_n, adv_n} = 3'b110;
      @(negedge clk);
      check(1, 2'd0, '0, 1'b0);  // R1
      rst_n = 1'b1;
      @(negedge clk);
      check(5, 2'd0, '0, 1'b0);  // R5 no burst active after reset
      // R8 linear full wrap from 01
      {start_proc_n, start_ctrl_n, adv_n} = 3'b101;
      addr_in = 18'h00011;
      @(negedge clk);
      check(3, 2'd1, 18'h00011, 1'b0);  // R3
      {start_proc_n, start_ctrl_n, adv_n} = 3'b110;
      for (int k = 1; k <= 4; k++) begin
         @(negedge clk);
         check(8, 2'd2, {16'h0004, 2'(1 + k)}, 1'b0);  // R8
      end
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule